// File: doc/BRIEF.md
# Interrupt Group Aggregator

This block sits between a chip's peripheral interrupt lines and the inputs of the CPU's interrupt controller. Sources are organised into groups of up to 32 lines. Each group keeps a latched status word, an enable mask written through separate set and clear registers, and a read-only result word (status AND enable). A source can reach the CPU only while its enable bit is set.

A single run-time control bit chooses the routing. With direct routing on, every result bit of a direct-capable group drives its own CPU input. With it off, the result bits of each group are ORed onto one CPU input per group. Groups that collect whole banks of general-purpose pins or virtual wires are marked by parameter as forced-aggregate and always use the OR path.

Software reaches the registers through a small request/response bus. The request side carries a valid/ready pair, but ready is tied high, so every request is accepted in the cycle it is presented. The response side has no back-pressure: each accepted read produces a response exactly one cycle later, and the requester must be able to take it.

Top module: `irq_group_agg`

## Requirements
- R1: Register word address = 4*group + selector, where selector 0 is status, 1 is enable-set, 2 is enable-clear and 3 is result. The control register sits at address 4*NUM_GROUPS, with bit 0 selecting direct routing. `req_ready` is always 1. A read accepted on one clock edge raises `rsp_valid` for exactly the following cycle, with the data in `rsp_rdata`. Reads of unmapped addresses return 0.
- R2: A status bit is set on every rising edge at which its source is sampled high, and it stays set after the source drops. If a source is high in the same cycle that its bit is cleared, the set wins, so a held source re-sets its bit.
- R3: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R4: Writing 1 to an enable-set bit enables that source, and writing 1 to the same bit of enable-clear disables it. Reading either address returns the current enable mask.
- R5: The result register reads status AND enable, and writes to it are ignored.
- R6: A latched source whose enable bit is clear drives no CPU output.
- R7: With direct routing on, each result bit of a direct-capable group appears on its own bit of `irq_direct`, and that group's `irq_group` bit is 0.
- R8: With direct routing off, a group's `irq_group` bit is the OR of its result bits, and its `irq_direct` bits are 0.
- R9: A forced-aggregate group always drives the OR of its result bits on `irq_group`, and its `irq_direct` bits are always 0.
- R10: Bit positions not implemented in a group read as 0, ignore writes and ignore their source line.
- R11: A synchronous active-high reset clears all status and enable bits, turns direct routing off and drops `rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_src | input | NUM_GROUPS*SRC_W | Source lines; group g occupies bits [g*SRC_W +: SRC_W] |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always 1) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Register word address |
| req_wdata | input | SRC_W | Write data |
| rsp_valid | output | 1 | Read data valid (one cycle after the read) |
| rsp_rdata | output | SRC_W | Read data |
| irq_direct | output | NUM_GROUPS*SRC_W | Per-bit CPU interrupt lines |
| irq_group | output | NUM_GROUPS | Per-group ORed CPU interrupt lines |

## Verification
A wrong status or enable bit shows up at the CPU lines on the cycle after the edge that stored it, because the outputs are combinational from the stored state. It also shows up in the response one cycle after a read of that group. A wrong routing decision shows up at once when the control bit toggles: the same result bit either moves between `irq_direct` and `irq_group` or fails to move. A forced-aggregate group exposes an error by driving a direct line while direct routing is on.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_EN_SET = 2'd1,
    SEL_EN_CLR = 2'd2,
    SEL_RESULT = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_group_regs.sv
module irq_group_regs #(
  parameter int SRC_W = 32,
  parameter logic [SRC_W-1:0] USED = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SRC_W-1:0] src,
  input  logic             wr_stat,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic [SRC_W-1:0] wdata,
  output logic [SRC_W-1:0] status_o,
  output logic [SRC_W-1:0] enable_o,
  output logic [SRC_W-1:0] result_o
);
  logic [SRC_W-1:0] status_q, enable_q, clr_mask;

  assign clr_mask = wr_stat ? wdata : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
    end else begin
      status_q <= ((status_q & ~clr_mask) | src) & USED;
      if (wr_set)
        enable_q <= (enable_q | wdata) & USED;
      else if (wr_clr)
        enable_q <= enable_q & ~wdata;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign result_o = status_q & enable_q;

  // R2
  src_latch_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status_q & $past(src & USED)) == $past(src & USED)));

  // R3
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stat |=> ((status_q & $past(wdata & ~src)) == '0));

  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> ((enable_q & $past(wdata & USED)) == $past(wdata & USED)));
endmodule

// File: rtl/irq_group_route.sv
module irq_group_route #(
  parameter int SRC_W = 32,
  parameter bit FORCE_AGG = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             direct_mode,
  input  logic [SRC_W-1:0] result,
  output logic [SRC_W-1:0] bit_out,
  output logic             or_out
);
  logic eff_direct;

  assign eff_direct = direct_mode & ~FORCE_AGG;
  assign bit_out    = eff_direct ? result : '0;
  assign or_out     = ~eff_direct & (|result);

  // R7
  route_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !((|bit_out) && or_out));
endmodule

// File: rtl/irq_group_agg.sv
module irq_group_agg
  import irq_agg_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int SRC_W = 32,
  parameter logic [NUM_GROUPS-1:0] AGG_GROUPS = 4'b1001,
  parameter logic [NUM_GROUPS*SRC_W-1:0] USED_BITS =
    {32'h0000_00FF, 32'hFFFF_FFFF, 32'h0000_FFFF, 32'hFFFF_FFFF},
  localparam int ADDR_W = $clog2(NUM_GROUPS*4 + 1),
  localparam int GRP_W = ADDR_W - 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_GROUPS*SRC_W-1:0] irq_src,
  input  logic                        req_valid,
  output logic                        req_ready,
  input  logic                        req_write,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [SRC_W-1:0]            req_wdata,
  output logic                        rsp_valid,
  output logic [SRC_W-1:0]            rsp_rdata,
  output logic [NUM_GROUPS*SRC_W-1:0] irq_direct,
  output logic [NUM_GROUPS-1:0]       irq_group
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_GROUPS*4);

  logic             wr_en, rd_en, direct_mode_q;
  logic [GRP_W-1:0] addr_grp;
  reg_sel_e         addr_sel;
  logic [SRC_W-1:0] rd_mux;
  logic [SRC_W-1:0] status_a [NUM_GROUPS];
  logic [SRC_W-1:0] enable_a [NUM_GROUPS];
  logic [SRC_W-1:0] result_a [NUM_GROUPS];

  assign req_ready = 1'b1;
  assign wr_en     = req_valid & req_write;
  assign rd_en     = req_valid & ~req_write;
  assign addr_grp  = req_addr[ADDR_W-1:2];
  assign addr_sel  = reg_sel_e'(req_addr[1:0]);

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    logic hit;
    assign hit = wr_en && (addr_grp == GRP_W'(g));

    irq_group_regs #(
      .SRC_W(SRC_W),
      .USED (USED_BITS[g*SRC_W +: SRC_W])
    ) i_regs (
      .clk     (clk),
      .rst     (rst),
      .src     (irq_src[g*SRC_W +: SRC_W]),
      .wr_stat (hit && addr_sel == SEL_STATUS),
      .wr_set  (hit && addr_sel == SEL_EN_SET),
      .wr_clr  (hit && addr_sel == SEL_EN_CLR),
      .wdata   (req_wdata),
      .status_o(status_a[g]),
      .enable_o(enable_a[g]),
      .result_o(result_a[g])
    );

    irq_group_route #(
      .SRC_W    (SRC_W),
      .FORCE_AGG(AGG_GROUPS[g])
    ) i_route (
      .clk        (clk),
      .rst        (rst),
      .direct_mode(direct_mode_q),
      .result     (result_a[g]),
      .bit_out    (irq_direct[g*SRC_W +: SRC_W]),
      .or_out     (irq_group[g])
    );
  end

  always_comb begin
    rd_mux = '0;
    if (req_addr == CTRL_ADDR) begin
      rd_mux[0] = direct_mode_q;
    end else begin
      for (int k = 0; k < NUM_GROUPS; k++) begin
        if (addr_grp == GRP_W'(k)) begin
          case (addr_sel)
            SEL_STATUS: rd_mux = status_a[k];
            SEL_EN_SET: rd_mux = enable_a[k];
            SEL_EN_CLR: rd_mux = enable_a[k];
            default:    rd_mux = result_a[k];
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      direct_mode_q <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_rdata     <= '0;
    end else begin
      rsp_valid <= rd_en;
      if (rd_en) rsp_rdata <= rd_mux;
      if (wr_en && req_addr == CTRL_ADDR) direct_mode_q <= req_wdata[0];
    end
  end

  // R1
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rsp_valid);

  // R1
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> !rsp_valid);

  // R11
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!direct_mode_q && !rsp_valid && irq_group == '0));
endmodule

// File: tb/test_irq_group_agg.sv
module test_irq_group_agg;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [127:0] irq_src = '0;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [4:0]   req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_ready, rsp_valid;
  logic [31:0]  rsp_rdata;
  logic [127:0] irq_direct;
  logic [3:0]   irq_group;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  irq_group_agg i_irq_group_agg (
    .clk(clk), .rst(rst), .irq_src(irq_src),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_direct(irq_direct), .irq_group(irq_group)
  );

  // scoreboard monitor
  always @(negedge clk) begin
    if (rsp_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R1 unexpected response got %h exp none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          errors++;
          $display("FAIL %s read got %h exp %h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic chk(input string t, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", t, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic pulse(input int idx);
    @(negedge clk);
    irq_src[idx] = 1'b1;
    @(negedge clk);
    irq_src[idx] = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    rd(5'd0, 32'h0, "R11 status");
    rd(5'd1, 32'h0, "R11 enable");
    rd(5'd16, 32'h0, "R11 ctrl");
    chk("R11 outputs", {irq_direct, 124'h0, irq_group} != 0, 1'b0);
    // R1 ready and unmapped read
    chk("R1 ready", req_ready, 1'b1);
    rd(5'd17, 32'h0, "R1 unmapped");
    // R2 latch, R6 no output when disabled
    pulse(5);
    rd(5'd0, 32'h20, "R2 latched");
    rd(5'd3, 32'h0, "R5 result disabled");
    chk("R6 disabled no irq", irq_group[0], 1'b0);
    // R4 enable, R5 result, R9 forced group ORs
    wr(5'd1, 32'h20);
    rd(5'd1, 32'h20, "R4 set read");
    rd(5'd2, 32'h20, "R4 clr read");
    rd(5'd3, 32'h20, "R5 result");
    chk("R9 group0 or", irq_group[0], 1'b1);
    wr(5'd3, 32'h0);
    rd(5'd3, 32'h20, "R5 result write ignored");
    // R3 w1c
    wr(5'd0, 32'hFFFF_FFDF);
    rd(5'd0, 32'h20, "R3 write0 no effect");
    wr(5'd0, 32'h20);
    rd(5'd0, 32'h0, "R3 w1c");
    chk("R3 irq cleared", irq_group[0], 1'b0);
    wr(5'd2, 32'h20);
    rd(5'd1, 32'h0, "R4 clear enable");
    // R2 held source re-sets
    @(negedge clk); irq_src[7] = 1'b1;
    wr(5'd0, 32'h80);
    rd(5'd0, 32'h80, "R2 held source");
    @(negedge clk); irq_src[7] = 1'b0;
    wr(5'd0, 32'h80);
    rd(5'd0, 32'h0, "R2 dropped then clear");
    // R8 group1 aggregate in mode 0
    pulse(35);
    wr(5'd5, 32'h8);
    chk("R8 group1 or", irq_group[1], 1'b1);
    chk("R8 group1 direct off", irq_direct[63:32], 32'h0);
    // R7 direct mode
    wr(5'd16, 32'h1);
    rd(5'd16, 32'h1, "R1 ctrl readback");
    chk("R7 direct bit", irq_direct[63:32], 32'h8);
    chk("R7 group1 or off", irq_group[1], 1'b0);
    // R9 forced group 3 in direct mode
    pulse(98);
    wr(5'd13, 32'h4);
    chk("R9 group3 or", irq_group[3], 1'b1);
    chk("R9 group3 direct zero", irq_direct[127:96], 32'h0);
    // R10 unused bits
    wr(5'd5, 32'hFFFF_FFFF);
    rd(5'd5, 32'h0000_FFFF, "R10 enable mask");
    pulse(52);
    rd(5'd4, 32'h8, "R10 unused source");
    chk("R10 unused direct", irq_direct[52], 1'b0);
    // R7/R8 group2 several bits
    pulse(64); pulse(95);
    wr(5'd9, 32'h8000_0001);
    chk("R7 group2 direct", irq_direct[95:64], 32'h8000_0001);
    wr(5'd16, 32'h0);
    chk("R8 group2 or", irq_group[2], 1'b1);
    chk("R8 all direct zero", irq_direct, 128'h0);
    // R11 reset mid run
    wr(5'd16, 32'h1);
    do_reset();
    rd(5'd16, 32'h0, "R11 ctrl after reset");
    rd(5'd4, 32'h0, "R11 status after reset");
    rd(5'd5, 32'h0, "R11 enable after reset");
    chk("R11 irq after reset", irq_group, 4'h0);
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R1 missing responses got %0d exp 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog got timeout exp completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule